// File: doc/BRIEF.md
# Delayed Write Request Queue

This block sits between the two sides of a bus bridge and carries non-posted single-DWORD writes, meaning I/O writes and type 1 configuration writes, across the bridge. The first time such a write appears it is answered with a retry, and its command, address, address parity, data DWORD, byte enables and data parity are stored in a small first-in first-out queue. The entry at the head goes out on the target side once a "posted data drained" input reports that earlier posted writes have left. The block reissues it after every target retry, and gives up with a system error once a selectable retry limit is reached.

The originating initiator keeps repeating its write. While the stored copy is still pending, each repeat gets another retry. Once the head entry has completed on the target side, a repeat that matches it exactly is accepted with target-ready, and the entry is removed in that same cycle. Bus pin timing and the posted-write path belong to other blocks.

Top module: `dly_write_queue`

## Requirements
- R1: Every `req_valid` cycle gets exactly one response in the next cycle. `rsp_valid` is high with either `rsp_retry` or `rsp_ack`, never both.
- R2: A queued entry is presented at the head with every captured field unchanged on the `tgt_*` outputs.
- R3: A request whose command and address equal those of any occupied entry is not enqueued again and is answered with a retry.
- R4: A new request that arrives while DEPTH entries are occupied is answered with a retry and is not stored.
- R5: `tgt_req` is asserted only while `posted_clear` is high and an uncompleted entry is at the head.
- R6: After `tgt_retry` below the limit, the same head entry stays presented, with `tgt_req` kept high.
- R7: When the retry count of the head entry reaches the limit (2^LO_LOG2 if `retry_sel`=0, 2^HI_LOG2 if 1), that entry is dropped. In the following cycle `serr` pulses high for one cycle if `serr_en` is 1. The count restarts for each new head entry.
- R8: With `serr_en`=0, a timeout still drops the entry, but `serr` stays low.
- R9: A repeat whose command, address, data and byte enables match a completed head entry gets `rsp_ack`. The entry is dequeued in that cycle, so the next entry is at the head one cycle later.
- R10: `rsp_stop` is asserted together with `rsp_ack` exactly when `req_multi` was high on the accepted repeat.
- R11: A repeat that matches a pending entry, or an entry that is not at the head, gets a retry and leaves the queue unchanged.
- R12: Entries are issued in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| posted_clear | input | 1 | Earlier posted writes have drained |
| retry_sel | input | 1 | 0: limit 2^LO_LOG2, 1: limit 2^HI_LOG2 |
| serr_en | input | 1 | System-error output enable |
| req_valid | input | 1 | Initiator write request this cycle |
| req_cmd | input | 4 | Bus command |
| req_addr | input | AW | Address |
| req_apar | input | 1 | Address parity |
| req_data | input | DW | First data DWORD |
| req_be | input | DW/8 | Byte enables |
| req_dpar | input | 1 | Data parity |
| req_multi | input | 1 | Initiator asks for more than one DWORD |
| rsp_valid | output | 1 | Response to last cycle's request |
| rsp_retry | output | 1 | Target retry |
| rsp_ack | output | 1 | Target-ready, write completed |
| rsp_stop | output | 1 | Disconnect together with ack |
| tgt_req | output | 1 | Issue head entry on target side |
| tgt_cmd | output | 4 | Head command |
| tgt_addr | output | AW | Head address |
| tgt_apar | output | 1 | Head address parity |
| tgt_data | output | DW | Head data |
| tgt_be | output | DW/8 | Head byte enables |
| tgt_dpar | output | 1 | Head data parity |
| tgt_ok | input | 1 | Target completed the issued write |
| tgt_retry | input | 1 | Target retried the issued write |
| serr | output | 1 | One-cycle system-error pulse |

## Verification
The bench sends a duplicate before the queue fills. A design that stores duplicates would hold the wrong second entry, and the wrong address would show at the head after the first completion. It sends a repeat of a non-head entry and a repeat of a still-pending head entry; a design that accepted either of them early would produce an ack where a retry belongs. It counts retries against both limit settings. An off-by-one count would drop the entry, or pulse `serr`, one retry early or late, and the bench also checks that `serr` stays low when it is disabled. It presents a request while the queue is full and checks that the queue is empty once drained, which exposes a design that overwrote an entry or wrapped its pointers.

// File: rtl/dly_write_queue.sv
module dly_write_queue #(
  parameter int DEPTH   = 4,
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int LO_LOG2 = 24,
  parameter int HI_LOG2 = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            posted_clear,
  input  logic            retry_sel,
  input  logic            serr_en,
  input  logic            req_valid,
  input  logic [3:0]      req_cmd,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_apar,
  input  logic [DW-1:0]   req_data,
  input  logic [DW/8-1:0] req_be,
  input  logic            req_dpar,
  input  logic            req_multi,
  output logic            rsp_valid,
  output logic            rsp_retry,
  output logic            rsp_ack,
  output logic            rsp_stop,
  output logic            tgt_req,
  output logic [3:0]      tgt_cmd,
  output logic [AW-1:0]   tgt_addr,
  output logic            tgt_apar,
  output logic [DW-1:0]   tgt_data,
  output logic [DW/8-1:0] tgt_be,
  output logic            tgt_dpar,
  input  logic            tgt_ok,
  input  logic            tgt_retry,
  output logic            serr
);
  localparam int PW = $clog2(DEPTH);
  localparam int BW = DW / 8;
  localparam int KW = 4 + AW;
  localparam int EW = KW + 1 + DW + BW + 1;
  localparam int CW = HI_LOG2 + 1;

  logic [EW-1:0]    slot [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [PW-1:0]    hd, tl;
  logic [PW:0]      used;
  logic             head_done;
  logic [CW-1:0]    tries;
  logic             dup;

  wire [EW-1:0] req_ent = {req_cmd, req_addr, req_apar, req_data, req_be, req_dpar};
  wire [EW-1:0] hent    = slot[hd];
  assign {tgt_cmd, tgt_addr, tgt_apar, tgt_data, tgt_be, tgt_dpar} = hent;

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (vld[i] && slot[i][EW-1 -: KW] == req_ent[EW-1 -: KW]) dup = 1'b1;
  end

  wire hit_head = vld[hd] && head_done &&
                  hent[EW-1 -: KW] == req_ent[EW-1 -: KW] &&
                  hent[DW+BW:1] == req_ent[DW+BW:1];
  wire full     = used == (PW+1)'(DEPTH);
  wire ack_now  = req_valid && hit_head;
  wire enq      = req_valid && !hit_head && !dup && !full;
  wire issue    = vld[hd] && !head_done && posted_clear;
  wire [CW-1:0] lim = retry_sel ? (CW'(1) << HI_LOG2) : (CW'(1) << LO_LOG2);
  wire give_up  = issue && tgt_retry && (tries + 1'b1 == lim);
  wire deq      = ack_now || give_up;

  assign tgt_req = issue;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0; hd <= '0; tl <= '0; used <= '0;
      head_done <= 1'b0; tries <= '0; serr <= 1'b0;
      rsp_valid <= 1'b0; rsp_retry <= 1'b0; rsp_ack <= 1'b0; rsp_stop <= 1'b0;
    end else begin
      if (enq) begin
        slot[tl] <= req_ent;
        vld[tl]  <= 1'b1;
        tl       <= tl + 1'b1;
      end
      if (deq) begin
        vld[hd] <= 1'b0;
        hd      <= hd + 1'b1;
      end
      used <= used + (PW+1)'(enq) - (PW+1)'(deq);
      if (deq) head_done <= 1'b0;
      else if (issue && tgt_ok) head_done <= 1'b1;
      if (deq) tries <= '0;
      else if (issue && tgt_retry) tries <= tries + 1'b1;
      serr      <= give_up && serr_en;
      rsp_valid <= req_valid;
      rsp_ack   <= ack_now;
      rsp_retry <= req_valid && !ack_now;
      rsp_stop  <= ack_now && req_multi;
    end
  end

  a_r1_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_retry, rsp_ack}) == 1);
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    used <= (PW+1)'(DEPTH));
  a_r6_head_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && tgt_retry && !give_up) |=> $stable(tgt_addr) && $stable(tgt_data));
  a_r7_serr_gated: assert property (@(posedge clk) disable iff (!rst_n)
    serr |-> $past(serr_en));
  a_r9_ack_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |-> $past(head_done));
  a_r10_stop_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_stop |-> rsp_ack);
endmodule

// File: tb/dly_write_queue_test.sv
module dly_write_queue_test;
  logic clk = 0, rst_n = 0;
  logic posted_clear = 0, retry_sel = 0, serr_en = 1;
  logic req_valid = 0, req_apar = 0, req_dpar = 0, req_multi = 0;
  logic [3:0] req_cmd = 0;
  logic [31:0] req_addr = 0, req_data = 0;
  logic [3:0] req_be = 0;
  logic tgt_ok = 0, tgt_retry = 0;
  logic rsp_valid, rsp_retry, rsp_ack, rsp_stop, tgt_req, tgt_apar, tgt_dpar, serr;
  logic [3:0] tgt_cmd, tgt_be;
  logic [31:0] tgt_addr, tgt_data;
  int checks = 0, errors = 0;
  logic [2:0] expq[$];

  always #4 clk = ~clk;

  dly_write_queue #(.DEPTH(4), .AW(32), .DW(32), .LO_LOG2(2), .HI_LOG2(3)) uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected code {stop, ack, retry}
  task automatic send(input logic [3:0] c, input logic [31:0] a, input logic [31:0] d,
                      input bit m, input logic [2:0] e);
    @(negedge clk);
    req_valid = 1; req_cmd = c; req_addr = a; req_data = d; req_be = 4'hF;
    req_apar = ^a; req_dpar = ^d; req_multi = m;
    expq.push_back(e);
    @(negedge clk);
    req_valid = 0; req_multi = 0;
  endtask

  task automatic tresp(input bit ok);
    @(negedge clk);
    tgt_ok = ok; tgt_retry = !ok;
    @(negedge clk);
    tgt_ok = 0; tgt_retry = 0;
  endtask

  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (expq.size() == 0) chk(0, "R1 unexpected response", 1, 0);
    else begin
      logic [2:0] e;
      e = expq.pop_front();
      chk({rsp_stop, rsp_ack, rsp_retry} == e, "R1/R9/R10/R11 response code",
          {rsp_stop, rsp_ack, rsp_retry}, e);
    end
  end

  localparam logic [2:0] RT = 3'b001, AK = 3'b010, AS = 3'b110;

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        chk(0, "watchdog", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!tgt_req && !rsp_valid && !serr, "R5 reset state", {tgt_req, rsp_valid, serr}, 0);
    send(4'h3, 32'h100, 32'hA1, 0, RT);
    @(negedge clk);
    chk(!tgt_req, "R5 held while posted data pending", tgt_req, 0);
    send(4'h3, 32'h100, 32'hEE, 0, RT);           // duplicate key, R3
    send(4'hB, 32'h200, 32'hB2, 0, RT);
    send(4'hB, 32'h300, 32'hC3, 0, RT);
    send(4'h3, 32'h400, 32'hD4, 0, RT);
    send(4'h3, 32'h500, 32'hE5, 0, RT);           // full, R4
    posted_clear = 1;
    @(negedge clk);
    chk(tgt_req && tgt_addr == 32'h100 && tgt_data == 32'hA1 && tgt_cmd == 4'h3 &&
        tgt_apar == ^32'h100 && tgt_dpar == ^32'hA1 && tgt_be == 4'hF,
        "R2 head fields", tgt_addr, 32'h100);
    send(4'h3, 32'h100, 32'hA1, 0, RT);           // R11 pending head
    tresp(0); tresp(0);
    chk(tgt_req && tgt_addr == 32'h100, "R6 reissue after retry", tgt_addr, 32'h100);
    tresp(1);
    chk(!tgt_req, "R5 no issue after completion", tgt_req, 0);
    send(4'hB, 32'h200, 32'hB2, 0, RT);           // R11 not head
    send(4'h3, 32'h100, 32'hA1, 0, AK);           // R9
    chk(tgt_req && tgt_addr == 32'h200, "R3/R9/R12 next head after ack", tgt_addr, 32'h200);
    repeat (3) tresp(0);
    chk(tgt_req && tgt_addr == 32'h200 && !serr, "R7 below limit 4", tgt_addr, 32'h200);
    tresp(0);
    chk(serr && tgt_addr == 32'h300, "R7 timeout at 4 raises serr", {serr, tgt_addr}, {1'b1, 32'h300});
    @(negedge clk);
    chk(!serr, "R7 serr one cycle", serr, 0);
    serr_en = 0; retry_sel = 1;
    repeat (7) tresp(0);
    chk(tgt_req && tgt_addr == 32'h300, "R7 below limit 8", tgt_addr, 32'h300);
    tresp(0);
    chk(!serr && tgt_addr == 32'h400, "R8 silent timeout", {serr, tgt_addr}, 32'h400);
    tresp(1);
    send(4'h3, 32'h400, 32'hD4, 1, AS);           // R10
    @(negedge clk);
    chk(!tgt_req, "R4 full request was not stored", tgt_req, 0);
    send(4'h3, 32'h500, 32'hE5, 0, RT);
    chk(tgt_req && tgt_addr == 32'h500, "R1 new request enqueued", tgt_addr, 32'h500);
    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R1 all responses seen", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule